// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in-first-out buffer, 9 bits wide by default, whose write port and read port run on independent clocks. The depth is a power-of-two parameter with a default of 512. Four active-low status flags are produced. Full and almost-full are registered in the write-clock domain. Empty and almost-empty are registered in the read-clock domain. The write and read pointers cross between the domains as Gray code through two-flop synchronizers.

One input pin has two possible meanings, and the block samples it while reset is held to choose one. If the pin is high during reset, it works as a second, active-high write enable, which allows several buffers to be chained in depth. If the pin is low during reset, it works as a load strobe. In that mode, pulling it low together with the primary write enable stores the data word into the next of four threshold slots instead of into the buffer. The thresholds set where almost-empty and almost-full switch. Both thresholds default to 7. The read side has an output-enable input, which here only qualifies a data-valid indication.

Top module: `dcfifo_pflag`

## Requirements
- R1: While `rst_n` is low on the clock edges, the buffer empties. `empty_n` and `aempty_n` are 0, `full_n` and `afull_n` are 1, `rd_data` is all zeros, `rd_data_vld` is 0, and both thresholds return to 7.
- R2: If `wr_en_b_ld` is 1 during reset, the block runs in dual-enable mode. A word is stored only when `wr_en_a_n`=0 and `wr_en_b_ld`=1. The combination `wr_en_a_n`=0 with `wr_en_b_ld`=0 stores nothing and leaves both thresholds at 7.
- R3: A read takes place on an `rd_clk` rising edge only when `rd_en_a_n`=0, `rd_en_b_n`=0 and the buffer is not empty. On that edge `rd_data` takes the oldest word. On any other edge `rd_data` holds its value.
- R4: Words leave the buffer in the order in which they were accepted.
- R5: Write requests are ignored while `full_n` is 0. Read requests are ignored while `empty_n` is 0.
- R6: With no reads, `full_n` stays 1 through DEPTH-1 writes and falls on the write edge of write number DEPTH.
- R7: `afull_n` is 0 exactly when the word count seen from the write side is at least DEPTH minus the almost-full threshold. It updates on the write edge that changes the count.
- R8: `empty_n` is 0 when the count seen from the read side is zero. `aempty_n` is 0 when that count is at most the almost-empty threshold. After a write, both flags settle within three `rd_clk` edges.
- R9: If `wr_en_b_ld` is 0 during reset, the block runs in threshold-load mode. `wr_en_a_n`=0 with `wr_en_b_ld`=1 stores a word. `wr_en_a_n`=0 with `wr_en_b_ld`=0 loads a threshold slot and stores nothing.
- R10: Load slots are taken in a fixed order: 0 is almost-empty bits [7:0], 1 is almost-empty bits [AW-1:8], 2 is almost-full bits [7:0], and 3 is almost-full bits [AW-1:8]. Each slot takes its bits from `wr_data[7:0]`, low bits first. After slot 3 the order wraps to slot 0. The position in the order is kept across ordinary writes.
- R11: `rd_data_vld` is 1 exactly when the previous `rd_clk` edge performed a read and `out_en_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_en_a_n | input | 1 | Primary write enable, active low |
| wr_en_b_ld | input | 1 | Second write enable or threshold-load strobe, chosen at reset |
| wr_data | input | DW | Write data, also the threshold load value |
| rd_clk | input | 1 | Read-side clock |
| rd_en_a_n | input | 1 | Read enable A, active low |
| rd_en_b_n | input | 1 | Read enable B, active low |
| out_en_n | input | 1 | Output enable, qualifies rd_data_vld |
| rst_n | input | 1 | Synchronous reset, active low, seen by both clocks |
| rd_data | output | DW | Registered read data |
| rd_data_vld | output | 1 | Read data valid and output enabled |
| empty_n | output | 1 | Empty flag, active low, read domain |
| full_n | output | 1 | Full flag, active low, write domain |
| aempty_n | output | 1 | Almost-empty flag, active low, read domain |
| afull_n | output | 1 | Almost-full flag, active low, write domain |

## Verification
A write pointer that skips or repeats shows up on `rd_data` as a lost or duplicated word at the first read of that slot. The scoreboard catches this on the read edge where the word leaves. A wrong count in the write domain moves the edge on which `full_n` or `afull_n` falls, and the bench checks that edge to the exact write. A fault in the read-side count or in a threshold shows up on `aempty_n` or `empty_n` within three read clocks of the triggering write. A slip in the load-slot order, or in the mode latched at reset, shows up as a threshold that moves by a known number of words.

// File: rtl/dcfifo_pkg.sv
`timescale 1ns/1ps
// Shared types for the dual-clock FIFO.
// Assumes: nothing beyond IEEE 1800-2017.
package dcfifo_pkg;
    // Meaning of the shared write-port pin, fixed while reset is held.
    typedef enum logic {
        MODE_DUAL_WE = 1'b0,
        MODE_PROG    = 1'b1
    } fifo_mode_e;

    // Threshold load slots in the order they are written.
    typedef enum logic [1:0] {
        SLOT_AE_LO = 2'd0,
        SLOT_AE_HI = 2'd1,
        SLOT_AF_LO = 2'd2,
        SLOT_AF_HI = 2'd3
    } off_slot_e;

    localparam int DFLT_OFFSET = 7;
endpackage

// File: rtl/dcfifo_gsync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a Gray-coded pointer.
// Assumes: at most one bit of the input changes per source clock.
module dcfifo_gsync #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Move the pointer into the destination clock through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dcfifo_mem.sv
`timescale 1ns/1ps
// Storage array: written on the write clock, read asynchronously.
// Assumes: the read side reads only slots that the synchronized write pointer shows as filled.
module dcfifo_mem #(
    parameter int DW = 9,
    parameter int AW = 9
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    // Store one word per accepted write.
    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dcfifo_wside.sv
`timescale 1ns/1ps
// Write-domain control: mode latch, write pointer, full and almost-full
// flags, and the threshold registers with their load order.
// Assumes: 9 <= AW <= 16; thresholds change only while the buffer is quiet.
module dcfifo_wside
    import dcfifo_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          en_a_n,
    input  logic          en_b_ld,
    input  logic [7:0]    ld_data,
    input  logic [AW:0]   rgray_s,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [AW:0]   wbin,
    output logic [AW:0]   wgray,
    output logic          full_n,
    output logic          afull_n,
    output logic [AW-1:0] ae_off
);
    localparam int          HW       = AW - 8;
    localparam logic [AW:0] FULL_CNT = {1'b1, {AW{1'b0}}};

    fifo_mode_e    mode;
    off_slot_e     slot;
    logic [AW-1:0] af_off;
    logic          push, load;
    logic [AW:0]   wbin_nx, rbin_s, used_nx;

    // Convert the synchronized Gray read pointer to binary.
    always_comb begin
        for (int i = 0; i <= AW; i++) rbin_s[i] = ^(rgray_s >> i);
    end

    assign push      = !en_a_n && en_b_ld && full_n;
    assign load      = (mode == MODE_PROG) && !en_a_n && !en_b_ld;
    assign wbin_nx   = wbin + {{AW{1'b0}}, push};
    assign used_nx   = wbin_nx - rbin_s;
    assign mem_we    = push;
    assign mem_waddr = wbin[AW-1:0];

    // Latch the meaning of the shared pin while reset is held.
    always_ff @(posedge wclk) begin
        if (!rst_n) mode <= en_b_ld ? MODE_DUAL_WE : MODE_PROG;
    end

    // Advance the write pointer and register the write-side flags.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wbin    <= '0;
            wgray   <= '0;
            full_n  <= 1'b1;
            afull_n <= 1'b1;
        end else begin
            wbin    <= wbin_nx;
            wgray   <= wbin_nx ^ (wbin_nx >> 1);
            full_n  <= (used_nx != FULL_CNT);
            afull_n <= (used_nx < (FULL_CNT - {1'b0, af_off}));
        end
    end

    // Load the threshold slots in order and wrap after the last one.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            ae_off <= AW'(DFLT_OFFSET);
            af_off <= AW'(DFLT_OFFSET);
            slot   <= SLOT_AE_LO;
        end else if (load) begin
            case (slot)
                SLOT_AE_LO: ae_off[7:0]    <= ld_data;
                SLOT_AE_HI: ae_off[AW-1:8] <= ld_data[HW-1:0];
                SLOT_AF_LO: af_off[7:0]    <= ld_data;
                SLOT_AF_HI: af_off[AW-1:8] <= ld_data[HW-1:0];
                default:    ;
            endcase
            slot <= off_slot_e'(slot + 2'd1);
        end
    end
endmodule

// File: rtl/dcfifo_rside.sv
`timescale 1ns/1ps
// Read-domain control: read pointer, output register, data-valid
// qualifier, and the empty and almost-empty flags.
// Assumes: ae_off is quasi-static (it changes only while the buffer is quiet).
module dcfifo_rside #(
    parameter int DW = 9,
    parameter int AW = 9
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          en_a_n,
    input  logic          en_b_n,
    input  logic          oe_n,
    input  logic [AW:0]   wgray_s,
    input  logic [AW-1:0] ae_off,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_raddr,
    output logic [AW:0]   rbin,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] q,
    output logic          q_vld,
    output logic          empty_n,
    output logic          aempty_n
);
    logic        pop, rd_last;
    logic [AW:0] rbin_nx, wbin_s, used_nx;

    // Convert the synchronized Gray write pointer to binary.
    always_comb begin
        for (int i = 0; i <= AW; i++) wbin_s[i] = ^(wgray_s >> i);
    end

    assign pop       = !en_a_n && !en_b_n && empty_n;
    assign rbin_nx   = rbin + {{AW{1'b0}}, pop};
    assign used_nx   = wbin_s - rbin_nx;
    assign mem_raddr = rbin[AW-1:0];
    assign q_vld     = rd_last && !oe_n;

    // Advance the read pointer, load the output word and register the read-side flags.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rbin     <= '0;
            rgray    <= '0;
            q        <= '0;
            rd_last  <= 1'b0;
            empty_n  <= 1'b0;
            aempty_n <= 1'b0;
        end else begin
            rbin     <= rbin_nx;
            rgray    <= rbin_nx ^ (rbin_nx >> 1);
            rd_last  <= pop;
            if (pop) q <= mem_rdata;
            empty_n  <= (used_nx != '0);
            aempty_n <= (used_nx > {1'b0, ae_off});
        end
    end
endmodule

// File: rtl/dcfifo_pflag.sv
`timescale 1ns/1ps
// Dual-clock FIFO with latched pin mode and programmable thresholds.
// Assumes: DEPTH is a power of two from 512 to 65536; rst_n is held for
// several edges of both clocks.
module dcfifo_pflag #(
    parameter int DW    = 9,
    parameter int DEPTH = 512
) (
    input  logic          wr_clk,
    input  logic          wr_en_a_n,
    input  logic          wr_en_b_ld,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_clk,
    input  logic          rd_en_a_n,
    input  logic          rd_en_b_n,
    input  logic          out_en_n,
    input  logic          rst_n,
    output logic [DW-1:0] rd_data,
    output logic          rd_data_vld,
    output logic          empty_n,
    output logic          full_n,
    output logic          aempty_n,
    output logic          afull_n
);
    localparam int AW = $clog2(DEPTH);

    logic [AW:0]   wr_ptr, rd_ptr, wr_gray, rd_gray, wr_gray_s, rd_gray_s;
    logic [AW-1:0] ae_off, mem_waddr, mem_raddr;
    logic [DW-1:0] mem_rdata;
    logic          mem_we;

    dcfifo_wside #(.AW(AW)) u_wside (
        .wclk(wr_clk), .rst_n(rst_n), .en_a_n(wr_en_a_n), .en_b_ld(wr_en_b_ld),
        .ld_data(wr_data[7:0]), .rgray_s(rd_gray_s), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .wbin(wr_ptr), .wgray(wr_gray),
        .full_n(full_n), .afull_n(afull_n), .ae_off(ae_off)
    );

    dcfifo_gsync #(.W(AW+1)) u_w2r (
        .clk(rd_clk), .rst_n(rst_n), .d(wr_gray), .q(wr_gray_s)
    );

    dcfifo_gsync #(.W(AW+1)) u_r2w (
        .clk(wr_clk), .rst_n(rst_n), .d(rd_gray), .q(rd_gray_s)
    );

    dcfifo_mem #(.DW(DW), .AW(AW)) u_mem (
        .wclk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );

    dcfifo_rside #(.DW(DW), .AW(AW)) u_rside (
        .rclk(rd_clk), .rst_n(rst_n), .en_a_n(rd_en_a_n), .en_b_n(rd_en_b_n),
        .oe_n(out_en_n), .wgray_s(wr_gray_s), .ae_off(ae_off),
        .mem_rdata(mem_rdata), .mem_raddr(mem_raddr), .rbin(rd_ptr),
        .rgray(rd_gray), .q(rd_data), .q_vld(rd_data_vld),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );
endmodule

// File: rtl/dcfifo_pflag_chk.sv
`timescale 1ns/1ps
// Property checker for dcfifo_pflag, attached by bind.
// Assumes: pointer ports are the binary write and read pointers of the top.
module dcfifo_pflag_chk #(
    parameter int DW = 9,
    parameter int AW = 9
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic          rd_en_a_n,
    input logic          rd_en_b_n,
    input logic          full_n,
    input logic          afull_n,
    input logic          empty_n,
    input logic          aempty_n,
    input logic [DW-1:0] rd_data,
    input logic [AW:0]   wr_ptr,
    input logic [AW:0]   rd_ptr
);
    a_r5_no_overflow: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |=> (wr_ptr == $past(wr_ptr)));

    a_r5_no_underflow: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |=> (rd_ptr == $past(rd_ptr)));

    a_r3_hold_data: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_en_a_n || rd_en_b_n) |=> $stable(rd_data));

    a_r7_full_in_afull: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |-> !afull_n);

    a_r8_empty_in_aempty: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);

    a_r4_wptr_step: assert property (@(posedge wr_clk) disable iff (!rst_n)
        ((AW+1)'(wr_ptr - $past(wr_ptr)) <= (AW+1)'(1)));
endmodule

bind dcfifo_pflag dcfifo_pflag_chk #(.DW(DW), .AW(AW)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n),
    .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n),
    .rd_data(rd_data), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
);

// File: tb/sim_dcfifo_pflag.sv
`timescale 1ns/1ps
// Scoreboard bench: the write task queues accepted words, and a monitor on
// the read clock compares each popped word with the head of the queue.
module sim_dcfifo_pflag;
    localparam int DW    = 9;
    localparam int DEPTH = 512;

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          wr_en_a_n = 1'b1, wr_en_b_ld = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en_a_n = 1'b1, rd_en_b_n = 1'b1, out_en_n = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_data_vld, empty_n, full_n, aempty_n, afull_n;

    int            n_chk = 0, n_fail = 0;
    bit            rd_fire = 1'b0;
    bit            done = 1'b0;
    logic [DW-1:0] sb [$];

    dcfifo_pflag #(.DW(DW), .DEPTH(DEPTH)) u0 (
        .wr_clk(wr_clk), .wr_en_a_n(wr_en_a_n), .wr_en_b_ld(wr_en_b_ld),
        .wr_data(wr_data), .rd_clk(rd_clk), .rd_en_a_n(rd_en_a_n),
        .rd_en_b_n(rd_en_b_n), .out_en_n(out_en_n), .rst_n(rst_n),
        .rd_data(rd_data), .rd_data_vld(rd_data_vld), .empty_n(empty_n),
        .full_n(full_n), .aempty_n(aempty_n), .afull_n(afull_n)
    );

    always #4 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #4 rd_clk = ~rd_clk;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Monitor: on each read edge the bench issued, compare with the queue head (R4).
    always @(posedge rd_clk) begin
        if (rd_fire) begin
            #1;
            if (sb.size() == 0) chk(1'b0, "R4 pop with empty scoreboard", int'(rd_data), -1);
            else begin
                logic [DW-1:0] e;
                e = sb.pop_front();
                chk(rd_data == e, "R4 read order", int'(rd_data), int'(e));
            end
        end
    end

    task automatic do_reset(input logic pin_b);
        @(negedge wr_clk);
        rst_n = 1'b0; wr_en_a_n = 1'b1; wr_en_b_ld = pin_b;
        rd_en_a_n = 1'b1; rd_en_b_n = 1'b1; rd_fire = 1'b0;
        repeat (5) @(negedge wr_clk);
        rst_n = 1'b1; wr_en_b_ld = 1'b1;
        sb.delete();
    endtask

    // Driver: one write request per write clock; the queue gets words the model says are accepted.
    task automatic wr_word(input logic [DW-1:0] d, input logic pin_b);
        @(negedge wr_clk);
        wr_en_a_n = 1'b0; wr_en_b_ld = pin_b; wr_data = d;
        if (pin_b && full_n === 1'b1) sb.push_back(d);
    endtask

    task automatic w_idle();
        @(negedge wr_clk);
        wr_en_a_n = 1'b1; wr_en_b_ld = 1'b1;
    endtask

    task automatic rd_word();
        @(negedge rd_clk);
        rd_en_a_n = 1'b0; rd_en_b_n = 1'b0;
        rd_fire = (empty_n === 1'b1);
    endtask

    task automatic r_idle();
        @(negedge rd_clk);
        rd_en_a_n = 1'b1; rd_en_b_n = 1'b1; rd_fire = 1'b0;
    endtask

    task automatic rd_n(input int n);
        for (int i = 0; i < n; i++) rd_word();
        r_idle();
    endtask

    task automatic settle();
        repeat (6) @(negedge rd_clk);
    endtask

    initial begin
        repeat (200000) @(posedge wr_clk);
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            summary();
        end
    end

    initial begin
        logic [DW-1:0] held;
        // Phase A: dual-enable mode.
        do_reset(1'b1);
        chk(empty_n == 1'b0, "R1 empty_n", empty_n, 0);
        chk(aempty_n == 1'b0, "R1 aempty_n", aempty_n, 0);
        chk(full_n == 1'b1, "R1 full_n", full_n, 1);
        chk(afull_n == 1'b1, "R1 afull_n", afull_n, 1);
        chk(rd_data == '0, "R1 rd_data", int'(rd_data), 0);
        chk(rd_data_vld == 1'b0, "R1 rd_data_vld", rd_data_vld, 0);

        for (int i = 0; i < 5; i++) wr_word(DW'(i + 100), 1'b0);
        w_idle(); settle();
        chk(empty_n == 1'b0, "R2 second enable low stores nothing", empty_n, 0);

        for (int i = 0; i < 20; i++) wr_word(DW'((i * 7 + 3) & 9'h1FF), 1'b1);
        w_idle(); settle();
        chk(empty_n == 1'b1, "R8 empty_n after writes", empty_n, 1);
        chk(aempty_n == 1'b1, "R8 aempty_n with 20 words", aempty_n, 1);
        rd_n(20);
        chk(rd_data_vld == 1'b1, "R11 valid after read", rd_data_vld, 1);
        out_en_n = 1'b1; #1;
        chk(rd_data_vld == 1'b0, "R11 output enable off", rd_data_vld, 0);
        out_en_n = 1'b0;
        @(negedge rd_clk);
        chk(rd_data_vld == 1'b0, "R11 no read last edge", rd_data_vld, 0);
        chk(empty_n == 1'b0, "R8 empty after draining", empty_n, 0);
        chk(sb.size() == 0, "R4 all words returned", sb.size(), 0);

        held = rd_data;
        rd_n(3);
        chk(rd_data == held, "R5 R3 read while empty holds data", int'(rd_data), int'(held));

        for (int i = 0; i < 7; i++) wr_word(DW'(i), 1'b1);
        w_idle(); settle();
        chk(aempty_n == 1'b0, "R2 threshold still 7 at 7 words", aempty_n, 0);
        wr_word(9'h055, 1'b1);
        w_idle(); settle();
        chk(aempty_n == 1'b1, "R2 threshold still 7 at 8 words", aempty_n, 1);
        rd_n(8);

        // Phase B: fill to full, then drain.
        do_reset(1'b1);
        chk(rd_data == '0, "R1 rd_data cleared by reset", int'(rd_data), 0);
        for (int i = 0; i < DEPTH - 8; i++) wr_word(DW'(i), 1'b1);
        w_idle();
        chk(afull_n == 1'b1, "R7 afull_n at DEPTH-8", afull_n, 1);
        wr_word(9'h0A5, 1'b1);
        w_idle();
        chk(afull_n == 1'b0, "R7 afull_n at DEPTH-7", afull_n, 0);
        for (int i = 0; i < 6; i++) wr_word(DW'(i + 300), 1'b1);
        w_idle();
        chk(full_n == 1'b1, "R6 full_n at DEPTH-1", full_n, 1);
        wr_word(9'h133, 1'b1);
        w_idle();
        chk(full_n == 1'b0, "R6 full_n at DEPTH", full_n, 0);
        wr_word(9'h1AB, 1'b1);
        w_idle();
        chk(full_n == 1'b0, "R5 write while full ignored", full_n, 0);
        rd_n(DEPTH - 8); settle();
        chk(aempty_n == 1'b1, "R8 aempty_n at 8 words", aempty_n, 1);
        rd_n(1); settle();
        chk(aempty_n == 1'b0, "R8 aempty_n at 7 words", aempty_n, 0);
        rd_n(7); settle();
        chk(empty_n == 1'b0, "R8 empty after full drain", empty_n, 0);
        chk(sb.size() == 0, "R5 ignored word not stored", sb.size(), 0);

        // Phase C: threshold-load mode.
        do_reset(1'b0);
        wr_word(9'd3, 1'b0);
        wr_word(9'd0, 1'b0);
        wr_word(9'd16, 1'b0);
        wr_word(9'd0, 1'b0);
        w_idle(); settle();
        chk(empty_n == 1'b0, "R9 load writes no word", empty_n, 0);
        for (int i = 0; i < 3; i++) wr_word(DW'(i + 40), 1'b1);
        w_idle(); settle();
        chk(aempty_n == 1'b0, "R10 almost-empty threshold 3 at 3 words", aempty_n, 0);
        wr_word(9'd43, 1'b1);
        w_idle(); settle();
        chk(aempty_n == 1'b1, "R10 almost-empty threshold 3 at 4 words", aempty_n, 1);
        wr_word(9'd5, 1'b0);
        w_idle(); settle();
        chk(aempty_n == 1'b0, "R10 slot order wraps to almost-empty", aempty_n, 0);
        for (int i = 0; i < 2; i++) wr_word(DW'(i + 50), 1'b1);
        w_idle(); settle();
        chk(aempty_n == 1'b1, "R10 threshold 5 at 6 words", aempty_n, 1);
        for (int i = 0; i < DEPTH - 23; i++) wr_word(DW'(i), 1'b1);
        w_idle();
        chk(afull_n == 1'b1, "R10 afull_n at DEPTH-17", afull_n, 1);
        wr_word(9'd7, 1'b1);
        w_idle();
        chk(afull_n == 1'b0, "R10 afull_n at DEPTH-16", afull_n, 0);
        chk(full_n == 1'b1, "R9 not full", full_n, 1);
        rd_n(10);

        done = 1'b1;
        summary();
    end
endmodule